// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block watches half-word writes aimed at an embedded flash array and turns them into commands. It recognises multi-write unlock sequences for programming a half-word, erasing the whole array and erasing sectors. It also accepts single-write commands to suspend or resume a sector erase and to return to the read state. Behind the decoder, a timed state machine stands in for the array's embedded algorithm. It reports busy and hang status, the current phase and the set of sectors being erased. It also emits one-cycle pulses whenever a program or an erase starts.

The decoder is active only while the 16-bit programming access mode is enabled. The program time, the chip and sector erase times, the window for collecting more sectors and the suspend latency are all counted in clock cycles set by parameters. A sector erase first opens a collection window; further sector codes written during that window join the same erase. A suspend takes effect at once during the window, and only after a latency once the erase is running. A program sent to an odd address never completes and leaves the block hung until a reset command arrives.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in the read state (code 0). busy, hang, sector_sel, prog_start and erase_start are all zero.
- R2: While prog_mode is 0, every write is ignored in every state.
- R3: Program is four writes. The first three are data 0xAA to address 0xAA8, then 0x55 to 0x554, then 0xA0 to 0xAA8. The fourth is any write, which is the target. Only data[7:0] and addr[11:0] are compared. The target write starts the program phase (code 1) with a one-cycle prog_start. The phase lasts PROG_CYC cycles and then returns to read.
- R4: A program whose target address has bit 0 set runs PROG_CYC cycles and then enters the hang state (code 6).
- R5: Chip erase is the unlock pair, then 0x80 to 0xAA8, the unlock pair again, then 0x10 to 0xAA8. It enters code 2 with erase_start and all sector_sel bits set. It lasts CHIP_CYC cycles and then returns to read with sector_sel cleared.
- R6: Sector erase matches chip erase except that the sixth write is 0x30 to any address. That write opens the window (code 3) and selects sector addr[SEC_SHIFT+:log2 NSEC]. After WIN_CYC cycles the erase phase (code 4) starts with erase_start. After ERASE_CYC erase cycles the block returns to read with sector_sel cleared.
- R7: Each 0x30 write during the window adds the addressed sector to sector_sel. It does not lengthen the window.
- R8: A write that does not match the next step of an unfinished sequence discards that sequence. It has no other effect, and a following complete sequence is accepted normally.
- R9: The following writes are ignored: every write during program and chip erase, every write except 0xF0 while hung, and every write except 0xB0 (and 0x30 in the window) during the window or the erase phase.
- R10: A 0xB0 write suspends the erase (code 5). In the window it acts on the next cycle. In the erase phase it acts SUSP_LAT cycles later, unless the erase ends first. It is ignored in read, program, chip erase and suspend.
- R11: In suspend, a 0x30 write resumes the erase phase directly with erase_start, and the remaining erase time is kept. Every other write is ignored in suspend. A 0x30 write in read does nothing.
- R12: A 0xF0 write in the hang state returns the block to read.
- R13: busy is 1 in codes 1, 2, 3, 4 and 6 and 0 in codes 0 and 5. hang is 1 only in code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Programming access mode enable |
| wr_en | input | 1 | Half-word write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 16 | Write data |
| busy | output | 1 | Algorithm running or hung |
| hang | output | 1 | Time limit exceeded; needs reset command |
| state_o | output | 3 | Current phase code |
| sector_sel | output | NSEC | Sectors selected for erase |
| prog_start | output | 1 | One-cycle pulse when a program starts |
| erase_start | output | 1 | One-cycle pulse when an erase starts or resumes |

## Verification
The hardest situation to reach is a suspend that is requested during the erase phase and then resumed. The latency counter and the erase counter run side by side, and after the resume the remaining time must be exactly what was left when the suspend took effect. The bench shortens every duration through parameters. It issues the suspend code a few cycles after the window has closed, and again near the end of an erase so that completion races the latency. A behavioural model that tracks the remaining erase cycles is compared on every clock.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 18,
  parameter int NSEC      = 4,
  parameter int SEC_SHIFT = 16,
  parameter int PROG_CYC  = 2000,
  parameter int CHIP_CYC  = 200000,
  parameter int ERASE_CYC = 100000,
  parameter int WIN_CYC   = 3500,
  parameter int SUSP_LAT  = 3500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              busy,
  output logic              hang,
  output logic [2:0]        state_o,
  output logic [NSEC-1:0]   sector_sel,
  output logic              prog_start,
  output logic              erase_start
);

  localparam int SW   = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int M1   = (CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC;
  localparam int MAXC = (M1 > WIN_CYC) ? M1 : WIN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int EW   = $clog2(ERASE_CYC + 1);
  localparam int LW   = $clog2(SUSP_LAT + 1);

  typedef enum logic [2:0] {
    S_READ = 3'd0, S_PROG = 3'd1, S_CHIP = 3'd2, S_WIN = 3'd3,
    S_SERA = 3'd4, S_SUSP = 3'd5, S_HANG = 3'd6
  } st_t;

  st_t           st;
  logic [2:0]    step;
  logic [CW-1:0] cnt;
  logic [EW-1:0] er_rem;
  logic [LW-1:0] sus_cnt;
  logic          sus_pend;
  logic          prog_bad;

  logic          wr;
  logic [7:0]    d;
  logic [11:0]   a;
  logic          at_aa8, at_554;
  logic          c_aa, c_55, c_a0, c_80, c_10, c_30, c_b0, c_f0;
  logic [SW-1:0] sec_idx;
  logic [NSEC-1:0] sec_bit;
  logic          unused_bits;

  assign wr      = wr_en & prog_mode;
  assign d       = wr_data[7:0];
  assign a       = wr_addr[11:0];
  assign at_aa8  = (a == 12'hAA8);
  assign at_554  = (a == 12'h554);
  assign c_aa    = wr & (d == 8'hAA) & at_aa8;
  assign c_55    = wr & (d == 8'h55) & at_554;
  assign c_a0    = wr & (d == 8'hA0) & at_aa8;
  assign c_80    = wr & (d == 8'h80) & at_aa8;
  assign c_10    = wr & (d == 8'h10) & at_aa8;
  assign c_30    = wr & (d == 8'h30);
  assign c_b0    = wr & (d == 8'hB0);
  assign c_f0    = wr & (d == 8'hF0);
  assign sec_idx = wr_addr[SEC_SHIFT +: SW];
  assign sec_bit = NSEC'(1) << sec_idx;
  assign unused_bits = ^{wr_data[15:8], wr_addr[ADDR_W-1:12]};

  assign state_o = st;
  assign hang    = (st == S_HANG);
  assign busy    = (st != S_READ) && (st != S_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_READ;
      step        <= 3'd0;
      cnt         <= '0;
      er_rem      <= '0;
      sus_cnt     <= '0;
      sus_pend    <= 1'b0;
      prog_bad    <= 1'b0;
      sector_sel  <= '0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      case (st)
        S_READ: if (wr) begin
          step <= 3'd0;
          case (step)
            3'd0: if (c_aa) step <= 3'd1;
            3'd1: if (c_55) step <= 3'd2;
            3'd2: if (c_a0) step <= 3'd3;
                  else if (c_80) step <= 3'd4;
            3'd3: begin
              st         <= S_PROG;
              cnt        <= CW'(PROG_CYC - 1);
              prog_bad   <= wr_addr[0];
              prog_start <= 1'b1;
            end
            3'd4: if (c_aa) step <= 3'd5;
            3'd5: if (c_55) step <= 3'd6;
            3'd6: if (c_10) begin
                    st          <= S_CHIP;
                    cnt         <= CW'(CHIP_CYC - 1);
                    sector_sel  <= '1;
                    erase_start <= 1'b1;
                  end else if (c_30) begin
                    st         <= S_WIN;
                    cnt        <= CW'(WIN_CYC - 1);
                    sector_sel <= sec_bit;
                  end
            default: ;
          endcase
        end
        S_PROG: begin
          if (cnt == '0) st <= prog_bad ? S_HANG : S_READ;
          else cnt <= cnt - 1'b1;
        end
        S_CHIP: begin
          if (cnt == '0) begin
            st         <= S_READ;
            sector_sel <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_WIN: begin
          if (c_b0) begin
            st     <= S_SUSP;
            er_rem <= EW'(ERASE_CYC - 1);
          end else begin
            if (c_30) sector_sel <= sector_sel | sec_bit;
            if (cnt == '0) begin
              st          <= S_SERA;
              er_rem      <= EW'(ERASE_CYC - 1);
              erase_start <= 1'b1;
            end else cnt <= cnt - 1'b1;
          end
        end
        S_SERA: begin
          if (er_rem == '0) begin
            st         <= S_READ;
            sector_sel <= '0;
            sus_pend   <= 1'b0;
          end else begin
            er_rem <= er_rem - 1'b1;
            if (sus_pend) begin
              if (sus_cnt == '0) begin
                st       <= S_SUSP;
                sus_pend <= 1'b0;
              end else sus_cnt <= sus_cnt - 1'b1;
            end else if (c_b0) begin
              sus_pend <= 1'b1;
              sus_cnt  <= LW'(SUSP_LAT - 1);
            end
          end
        end
        S_SUSP: if (c_30) begin
          st          <= S_SERA;
          erase_start <= 1'b1;
        end
        S_HANG: if (c_f0) st <= S_READ;
        default: st <= S_READ;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int NSEC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            prog_mode,
  input logic            wr_en,
  input logic            busy,
  input logic            hang,
  input logic [2:0]      state_o,
  input logic [NSEC-1:0] sector_sel,
  input logic            prog_start,
  input logic            erase_start
);

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_o == 3'd0 && !busy && sector_sel == '0));

  a_r2_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && wr_en && state_o == 3'd0) |=> state_o == 3'd0);

  a_r3_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (state_o == 3'd1 && $past(state_o) == 3'd0));

  a_r5_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (state_o == 3'd2 || state_o == 3'd4));

  a_r6_sel_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd6) |-> sector_sel == '0);

  a_r10_susp_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |-> sector_sel != '0);

  a_r11_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && $past(state_o) == 3'd5) |-> erase_start);

  a_r13_hang_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hang |-> (busy && state_o == 3'd6));

  a_r13_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 3'd7);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .wr_en(wr_en),
  .busy(busy), .hang(hang), .state_o(state_o), .sector_sel(sector_sel),
  .prog_start(prog_start), .erase_start(erase_start)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
  localparam int AW = 18, NS = 4, PC = 6, CC = 10, EC = 12, WC = 8, SL = 3;

  logic clk = 1'b0, rst_n = 1'b0, prog_mode = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, hang, prog_start, erase_start;
  logic [2:0] state_o;
  logic [NS-1:0] sector_sel;

  always #2 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .NSEC(NS), .SEC_SHIFT(16), .PROG_CYC(PC),
    .CHIP_CYC(CC), .ERASE_CYC(EC), .WIN_CYC(WC), .SUSP_LAT(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .hang(hang),
    .state_o(state_o), .sector_sel(sector_sel), .prog_start(prog_start),
    .erase_start(erase_start));

  int checks = 0, failures = 0;
  string tag = "R1";
  bit finished = 0;

  int m_st = 0, m_t = 0, m_left = 0, m_wait = 0, m_sel = 0;
  bit m_bad = 0, m_ps = 0, m_es = 0;
  int hist[$];

  function automatic int classify();
    int n = hist.size();
    if (hist[0] != 'hAA8AA) return 0;
    if (n == 1) return 1;
    if (hist[1] != 'h55455) return 0;
    if (n == 2) return 1;
    if (hist[2] == 'hAA8A0) return (n == 3) ? 1 : 2;
    if (hist[2] != 'hAA880) return 0;
    if (n == 3) return 1;
    if (hist[3] != 'hAA8AA) return 0;
    if (n == 4) return 1;
    if (hist[4] != 'h55455) return 0;
    if (n == 5) return 1;
    if (hist[5] == 'hAA810) return 3;
    if ((hist[5] & 'hFF) == 'h30) return 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sel = 0; m_ps = 0; m_es = 0; m_wait = 0; hist.delete();
    end else begin
      bit w;
      int dd, sb, k;
      w  = wr_en && prog_mode;
      dd = int'(wr_data[7:0]);
      sb = 1 << int'(wr_addr[17:16]);
      m_ps = 0; m_es = 0;
      case (m_st)
        0: if (w) begin
          hist.push_back((int'(wr_addr[11:0]) << 8) | dd);
          k = classify();
          if (k != 1) hist.delete();
          if (k == 2) begin m_st = 1; m_t = PC; m_bad = wr_addr[0]; m_ps = 1; end
          if (k == 3) begin m_st = 2; m_t = CC; m_sel = 15; m_es = 1; end
          if (k == 4) begin m_st = 3; m_t = WC; m_sel = sb; end
        end
        1: begin m_t--; if (m_t == 0) m_st = m_bad ? 6 : 0; end
        2: begin m_t--; if (m_t == 0) begin m_st = 0; m_sel = 0; end end
        3: if (w && dd == 'hB0) begin m_st = 5; m_left = EC; end
           else begin
             if (w && dd == 'h30) m_sel |= sb;
             m_t--;
             if (m_t == 0) begin m_st = 4; m_left = EC; m_es = 1; end
           end
        4: begin
          m_left--;
          if (m_left == 0) begin m_st = 0; m_sel = 0; m_wait = 0; end
          else if (m_wait > 0) begin m_wait--; if (m_wait == 0) m_st = 5; end
          else if (w && dd == 'hB0) m_wait = SL;
        end
        5: if (w && dd == 'h30) begin m_st = 4; m_es = 1; end
        6: if (w && dd == 'hF0) m_st = 0;
        default: ;
      endcase
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    bit eb;
    eb = (m_st == 1 || m_st == 2 || m_st == 3 || m_st == 4 || m_st == 6);
    chk(int'(state_o) == m_st, "state", int'(state_o), m_st);
    chk(busy == eb, "busy (R13)", int'(busy), int'(eb));
    chk(hang == (m_st == 6), "hang (R13)", int'(hang), int'(m_st == 6));
    chk(int'(sector_sel) == m_sel, "sector_sel", int'(sector_sel), m_sel);
    chk(prog_start == m_ps, "prog_start", int'(prog_start), int'(m_ps));
    chk(erase_start == m_es, "erase_start", int'(erase_start), int'(m_es));
  end

  task automatic wr(input logic [AW-1:0] ad, input logic [15:0] dt);
    @(negedge clk); wr_en = 1'b1; wr_addr = ad; wr_data = dt;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic expect_st(int e, string what);
    @(negedge clk); #1;
    chk(int'(state_o) == e, what, int'(state_o), e);
  endtask
  task automatic unl(); wr(18'h0AA8, 16'h00AA); wr(18'h0554, 16'h0055); endtask
  task automatic prog(logic [AW-1:0] t); unl(); wr(18'h3AA8, 16'hC3A0); wr(t, 16'h1234); endtask
  task automatic pre_erase(); unl(); wr(18'h0AA8, 16'h0080); unl(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    tag = "R1"; expect_st(0, "R1 reset state");
    rst_n = 1'b1; idle(2);
    tag = "R2"; prog(18'h00010); idle(3); expect_st(0, "R2 locked mode ignored");
    prog_mode = 1'b1;
    tag = "R11"; wr(18'h10000, 16'h0030); expect_st(0, "R11 resume in read ignored");
    tag = "R3"; prog(18'h10010); expect_st(1, "R3 program running");
    tag = "R9"; wr(18'h0, 16'h00B0); wr(18'h0, 16'h00F0); idle(PC); expect_st(0, "R9 R3 program done");
    tag = "R4"; prog(18'h10011); idle(PC + 2); expect_st(6, "R4 odd target hangs");
    tag = "R9"; wr(18'h0, 16'h00B0); unl(); expect_st(6, "R9 hang ignores other writes");
    tag = "R12"; wr(18'h2ABC, 16'hFFF0); expect_st(0, "R12 reset from hang");
    tag = "R5"; pre_erase(); wr(18'h0AA8, 16'h0010); expect_st(2, "R5 chip erase");
    tag = "R10"; wr(18'h0, 16'h00B0); idle(CC); expect_st(0, "R10 R5 chip erase done");
    tag = "R8"; wr(18'h0AA8, 16'h00AA); wr(18'h0554, 16'h0055); wr(18'h0AA8, 16'h0077);
    wr(18'h0AA8, 16'h00AA); wr(18'h0555, 16'h0055); wr(18'h0AA8, 16'h00A0);
    expect_st(0, "R8 broken sequences idle");
    prog(18'h20020); expect_st(1, "R8 fresh program accepted"); idle(PC + 1);
    tag = "R6"; pre_erase(); wr(18'h10002, 16'h0030); expect_st(3, "R6 window open");
    tag = "R7"; wr(18'h30000, 16'h0030); idle(WC); expect_st(4, "R7 R6 erase running");
    idle(EC + 1); expect_st(0, "R6 erase done");
    tag = "R10"; pre_erase(); wr(18'h20000, 16'h0030); wr(18'h0, 16'h00B0);
    expect_st(5, "R10 suspend in window");
    tag = "R11"; prog(18'h00040); wr(18'h0, 16'h00B0); wr(18'h0, 16'h00F0);
    expect_st(5, "R11 suspend ignores commands");
    wr(18'h0, 16'h0030); expect_st(4, "R11 resume to erase");
    tag = "R10"; idle(2); wr(18'h0, 16'h00B0); idle(SL + 1); expect_st(5, "R10 latency suspend");
    tag = "R11"; wr(18'h0, 16'h0030); idle(EC); expect_st(0, "R11 remaining time kept");
    tag = "R10"; pre_erase(); wr(18'h00000, 16'h0030); idle(WC + EC - 4);
    wr(18'h0, 16'h00B0); idle(SL + 2); expect_st(0, "R10 erase end beats suspend");
    idle(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule